// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus-side controller for a 16-bit minimum-mode processor bus where the low address bits and the data share one set of lines. A core-side requester presents an address, a memory/I-O flag, a direction flag, write data and a high-byte enable. The sequencer then runs one complete bus cycle of four states named T1, T2, T3 and T4, plus any wait states (Tw) that the slave asks for by holding READY low.

It drives the address strobe, the read and write strobes, the transceiver direction and enable, and the memory/I-O line. It also drives the shared low lines and the upper address/status lines. On the last state it returns captured read data with a one-cycle done pulse.

The shared low bus is split into an output value, an output enable and an input value. An external pad ring or an external tristate stage joins them. All strobes named with `_n` are active low.

Top module: `mbus_cycle_seq`

## Requirements
- R1: A synchronous reset, whether applied at start-up or part-way through a cycle, puts the block in idle on the next clock: req_ready=1, ale=0, rd_n=1, wr_n=1, den_n=1, ad_oe=0, dtr=0, mio=0, bhe_n=1, ahi_out=0, rsp_done=0.
- R2: A request is taken on a rising edge where req_valid and req_ready are both 1. The following cycle is T1. In T1, ale=1, ad_oe=1, ad_out holds address bits [DATA_W-1:0] and ahi_out holds the remaining upper address bits.
- R3: From T2 through T4, ahi_out carries status instead of address. Bit 0 is the memory/I-O flag, bit 1 is the write flag, and all higher bits are 0.
- R4: In a read cycle, rd_n is 0 in T2, T3 and every Tw. ad_oe is 0 from T2 through T4, which leaves the lines free for the slave.
- R5: In a write cycle, wr_n is 0 in T2, T3 and every Tw. ad_oe is 1 and ad_out equals the write data from T2 through T4.
- R6: READY is sampled only on the edge that ends T3 or a Tw. A 0 there adds one Tw, so a cycle lasts 4 + N clocks for N consecutive low samples. READY values during T1 and T2 have no effect.
- R7: For the whole cycle from T1 through T4, dtr equals the write flag and mio equals the memory/I-O flag. den_n is 0 in T2 through T4 only.
- R8: rsp_done is 1 for exactly the T4 cycle. For reads, rsp_rdata in T4 equals the ad_in value present on the edge that ended the last T3 or Tw.
- R9: req_ready is 0 from T1 through T4. A req_valid raised in that span is ignored: it does not change the current cycle's pins and does not start a new cycle.
- R10: bhe_n is the inverse of the requested high-byte enable from T1 through T4, and 1 in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | ADDR_W | Physical address of the transfer |
| req_mio | input | 1 | 1 = memory, 0 = I/O |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_bhe | input | 1 | High byte lane wanted |
| ready | input | 1 | Slave ready, already synchronised |
| ad_in | input | DATA_W | Shared low lines, input side |
| ad_out | output | DATA_W | Shared low lines, output value |
| ad_oe | output | 1 | Output enable for the shared low lines |
| ahi_out | output | ADDR_W-DATA_W | Upper address bits in T1, status afterwards |
| bhe_n | output | 1 | High byte enable, active low |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| dtr | output | 1 | Transceiver direction, 1 = transmit |
| den_n | output | 1 | Transceiver enable, active low |
| mio | output | 1 | Memory/I-O indication |
| rsp_done | output | 1 | One-cycle completion pulse in T4 |
| rsp_rdata | output | DATA_W | Captured read data |

## Verification
The sweep covers every combination of direction, space flag and high-byte enable, each with zero to four wait states.

- Wait-state insertion: a sequencer that samples READY one state early, or stops at one Tw, would produce cycle lengths that differ from 4 + N. This shows up as an early done pulse or a strobe released too soon.
- READY in T1 and T2: READY is toggled during these states to catch a design that samples it too early.
- Read data capture: ad_in changes every cycle, so a capture one edge off returns the wrong word.
- Busy requests: req_valid is raised while a cycle is in progress, to catch a design that restarts or corrupts the cycle.
- Mid-cycle reset: reset is applied inside a Tw, to catch strobes left active afterwards.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_T3   = 3'd3,
      ST_TW   = 3'd4,
      ST_T4   = 3'd5
   } bus_state_e;

   // Number of status bits carried on the upper lines after T1
   localparam int STATUS_BITS = 2;

endpackage

// File: rtl/mbus_seq_fsm.sv
module mbus_seq_fsm
   import mbus_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_mio,
   input  logic              req_wr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_bhe,
   input  logic              ready,
   input  logic [DATA_W-1:0] ad_in,
   output bus_state_e        state,
   output logic [ADDR_W-1:0] q_addr,
   output logic              q_mio,
   output logic              q_wr,
   output logic [DATA_W-1:0] q_wdata,
   output logic              q_bhe,
   output logic [DATA_W-1:0] rdata_q
);

   bus_state_e nxt;
   logic       accept;
   logic       sample_pt;

   assign accept    = (state == ST_IDLE) && req_valid;
   assign sample_pt = (state == ST_T3) || (state == ST_TW);

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: if (req_valid) nxt = ST_T1;
         ST_T1:   nxt = ST_T2;
         ST_T2:   nxt = ST_T3;
         ST_T3,
         ST_TW:   nxt = ready ? ST_T4 : ST_TW;
         ST_T4:   nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_IDLE;
         q_addr  <= '0;
         q_mio   <= 1'b0;
         q_wr    <= 1'b0;
         q_wdata <= '0;
         q_bhe   <= 1'b0;
         rdata_q <= '0;
      end else begin
         state <= nxt;
         if (accept) begin
            q_addr  <= req_addr;
            q_mio   <= req_mio;
            q_wr    <= req_wr;
            q_wdata <= req_wdata;
            q_bhe   <= req_bhe;
         end
         if (sample_pt && ready && !q_wr) begin
            rdata_q <= ad_in;
         end
      end
   end

endmodule

// File: rtl/mbus_pin_drv.sv
module mbus_pin_drv
   import mbus_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  bus_state_e                 state,
   input  logic [ADDR_W-1:0]          q_addr,
   input  logic                       q_mio,
   input  logic                       q_wr,
   input  logic [DATA_W-1:0]          q_wdata,
   input  logic                       q_bhe,
   output logic [DATA_W-1:0]          ad_out,
   output logic                       ad_oe,
   output logic [ADDR_W-DATA_W-1:0]   ahi_out,
   output logic                       bhe_n,
   output logic                       ale,
   output logic                       rd_n,
   output logic                       wr_n,
   output logic                       dtr,
   output logic                       den_n,
   output logic                       mio
);

   localparam int HI_W = ADDR_W - DATA_W;

   logic [HI_W-1:0] status_w;
   logic            in_cycle;
   logic            addr_ph;
   logic            data_ph;
   logic            strobe_ph;

   generate
      if (HI_W == STATUS_BITS) begin : g_status_exact
         assign status_w = {q_wr, q_mio};
      end else begin : g_status_pad
         assign status_w = {{(HI_W-STATUS_BITS){1'b0}}, q_wr, q_mio};
      end
   endgenerate

   assign addr_ph   = (state == ST_T1);
   assign strobe_ph = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);
   assign data_ph   = strobe_ph || (state == ST_T4);
   assign in_cycle  = addr_ph || data_ph;

   always_comb begin
      ale     = addr_ph;
      rd_n    = !(strobe_ph && !q_wr);
      wr_n    = !(strobe_ph && q_wr);
      den_n   = !data_ph;
      dtr     = in_cycle && q_wr;
      mio     = in_cycle && q_mio;
      bhe_n   = !(in_cycle && q_bhe);
      ad_oe   = addr_ph || (data_ph && q_wr);
      ad_out  = '0;
      ahi_out = '0;
      if (addr_ph) begin
         ad_out  = q_addr[DATA_W-1:0];
         ahi_out = q_addr[ADDR_W-1:DATA_W];
      end else if (data_ph) begin
         ahi_out = status_w;
         if (q_wr) ad_out = q_wdata;
      end
   end

endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
   import mbus_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic                      req_mio,
   input  logic                      req_wr,
   input  logic [DATA_W-1:0]         req_wdata,
   input  logic                      req_bhe,
   input  logic                      ready,
   input  logic [DATA_W-1:0]         ad_in,
   output logic [DATA_W-1:0]         ad_out,
   output logic                      ad_oe,
   output logic [ADDR_W-DATA_W-1:0]  ahi_out,
   output logic                      bhe_n,
   output logic                      ale,
   output logic                      rd_n,
   output logic                      wr_n,
   output logic                      dtr,
   output logic                      den_n,
   output logic                      mio,
   output logic                      rsp_done,
   output logic [DATA_W-1:0]         rsp_rdata
);

   localparam int HI_W = ADDR_W - DATA_W;

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("mbus_cycle_seq: DATA_W must be at least 2");
      end
      if (HI_W < STATUS_BITS) begin : g_bad_hi_w
         $error("mbus_cycle_seq: ADDR_W must exceed DATA_W by at least STATUS_BITS");
      end
   endgenerate

   bus_state_e        state;
   logic [ADDR_W-1:0] q_addr;
   logic              q_mio;
   logic              q_wr;
   logic [DATA_W-1:0] q_wdata;
   logic              q_bhe;
   logic [DATA_W-1:0] rdata_q;

   mbus_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_mio   (req_mio),
      .req_wr    (req_wr),
      .req_wdata (req_wdata),
      .req_bhe   (req_bhe),
      .ready     (ready),
      .ad_in     (ad_in),
      .state     (state),
      .q_addr    (q_addr),
      .q_mio     (q_mio),
      .q_wr      (q_wr),
      .q_wdata   (q_wdata),
      .q_bhe     (q_bhe),
      .rdata_q   (rdata_q)
   );

   mbus_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
      .state   (state),
      .q_addr  (q_addr),
      .q_mio   (q_mio),
      .q_wr    (q_wr),
      .q_wdata (q_wdata),
      .q_bhe   (q_bhe),
      .ad_out  (ad_out),
      .ad_oe   (ad_oe),
      .ahi_out (ahi_out),
      .bhe_n   (bhe_n),
      .ale     (ale),
      .rd_n    (rd_n),
      .wr_n    (wr_n),
      .dtr     (dtr),
      .den_n   (den_n),
      .mio     (mio)
   );

   assign req_ready = (state == ST_IDLE);
   assign rsp_done  = (state == ST_T4);
   assign rsp_rdata = rdata_q;

endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk (
   input logic clk,
   input logic rst,
   input logic req_valid,
   input logic req_ready,
   input logic ready,
   input logic ale,
   input logic rd_n,
   input logic wr_n,
   input logic den_n,
   input logic ad_oe,
   input logic dtr,
   input logic rsp_done
);

   logic strobe;
   assign strobe = !rd_n || !wr_n;

   a_r2_accept_ale: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> ale);

   a_r2_ale_pulse: assert property (@(posedge clk) disable iff (rst)
      ale |=> !ale);

   a_r9_ale_from_idle: assert property (@(posedge clk) disable iff (rst)
      ale |-> $past(req_ready));

   a_r5_strobe_excl: assert property (@(posedge clk) disable iff (rst)
      !(!rd_n && !wr_n));

   a_r6_wait_hold: assert property (@(posedge clk) disable iff (rst)
      (strobe && !ready) |=> strobe);

   a_r8_done_after_ready: assert property (@(posedge clk) disable iff (rst)
      rsp_done |-> ($past(ready) && $past(strobe)));

   a_r4_read_release: assert property (@(posedge clk) disable iff (rst)
      !rd_n |-> !ad_oe);

   a_r7_dtr_steady: assert property (@(posedge clk) disable iff (rst)
      (!req_ready && !ale) |-> $stable(dtr));

   a_r7_den_off_in_t1: assert property (@(posedge clk) disable iff (rst)
      ale |-> den_n);

endmodule

bind mbus_cycle_seq mbus_seq_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .ready     (ready),
   .ale       (ale),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .den_n     (den_n),
   .ad_oe     (ad_oe),
   .dtr       (dtr),
   .rsp_done  (rsp_done)
);

// File: tb/mbus_cycle_seq_tb.sv
module mbus_cycle_seq_tb;

   localparam int AW = 20;
   localparam int DW = 16;
   localparam int HW = AW - DW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          req_mio = 1'b0;
   logic          req_wr = 1'b0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_bhe = 1'b0;
   logic          ready = 1'b1;
   logic [DW-1:0] ad_in = '0;
   logic [DW-1:0] ad_out;
   logic          ad_oe;
   logic [HW-1:0] ahi_out;
   logic          bhe_n, ale, rd_n, wr_n, dtr, den_n, mio, rsp_done;
   logic [DW-1:0] rsp_rdata;

   mbus_cycle_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_mio(req_mio), .req_wr(req_wr),
      .req_wdata(req_wdata), .req_bhe(req_bhe), .ready(ready), .ad_in(ad_in),
      .ad_out(ad_out), .ad_oe(ad_oe), .ahi_out(ahi_out), .bhe_n(bhe_n),
      .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .dtr(dtr), .den_n(den_n),
      .mio(mio), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
   );

   always #10 clk = ~clk;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  reported = 1'b0;

   logic [AW-1:0] e_addr;
   logic          e_mio, e_wr, e_bhe;
   logic [DW-1:0] e_wdata;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      end
   endtask

   // ph: 0 idle, 1 T1, 2 strobe state (T2/T3/Tw), 4 T4
   task automatic expect_pins(input int ph);
      logic          inc;
      logic          oe;
      logic [HW-1:0] hi;
      inc = (ph != 0);
      oe  = (ph == 1) || (ph >= 2 && e_wr);
      hi  = (ph == 1) ? e_addr[AW-1:DW] :
            (ph >= 2) ? HW'({e_wr, e_mio}) : '0;
      chk("R2 ale", 32'(ale), 32'(ph == 1));
      chk("R4 rd_n", 32'(rd_n), 32'(!(ph == 2 && !e_wr)));
      chk("R5 wr_n", 32'(wr_n), 32'(!(ph == 2 && e_wr)));
      chk("R7 den_n", 32'(den_n), 32'(!(ph >= 2)));
      chk("R7 dtr", 32'(dtr), 32'(inc && e_wr));
      chk("R7 mio", 32'(mio), 32'(inc && e_mio));
      chk("R10 bhe_n", 32'(bhe_n), 32'(!(inc && e_bhe)));
      chk("R4 R5 ad_oe", 32'(ad_oe), 32'(oe));
      chk(ph == 1 ? "R2 ahi_out" : "R3 ahi_out", 32'(ahi_out), 32'(hi));
      if (ph == 1) chk("R2 ad_out", 32'(ad_out), 32'(e_addr[DW-1:0]));
      else if (ph >= 2 && e_wr) chk("R5 ad_out", 32'(ad_out), 32'(e_wdata));
      chk("R9 req_ready", 32'(req_ready), 32'(ph == 0));
      chk("R8 rsp_done", 32'(rsp_done), 32'(ph == 4));
   endtask

   task automatic run_cycle(input logic [AW-1:0] a, input logic m, input logic w,
                            input logic [DW-1:0] wd, input logic b, input int nw,
                            input logic [DW-1:0] rv, input bit poke);
      @(negedge clk);
      req_addr = a; req_mio = m; req_wr = w; req_wdata = wd; req_bhe = b;
      req_valid = 1'b1;
      e_addr = a; e_mio = m; e_wr = w; e_wdata = wd; e_bhe = b;
      @(negedge clk);                      // T1
      expect_pins(1);
      req_valid = poke;                    // R9: request while busy
      if (poke) begin
         req_addr = ~a; req_wr = ~w; req_wdata = ~wd; req_mio = ~m; req_bhe = ~b;
      end
      ready = nw[0];                       // R6: ignored in T1
      ad_in = rv ^ 16'h0f0f;
      @(negedge clk);                      // T2
      expect_pins(2);
      ready = ~nw[0];                      // R6: ignored in T2
      ad_in = rv ^ 16'h5a5a;
      @(negedge clk);                      // T3
      expect_pins(2);
      ready = (nw == 0);
      ad_in = (nw == 0) ? rv : rv ^ 16'h1111;
      for (int k = 1; k <= nw; k++) begin
         @(negedge clk);                   // Tw number k
         expect_pins(2);
         chk("R6 no early done", 32'(rsp_done), 32'd0);
         ready = (k == nw);
         ad_in = (k == nw) ? rv : rv ^ DW'(k);
      end
      @(negedge clk);                      // T4
      req_valid = 1'b0;
      expect_pins(4);
      if (!w) chk("R8 rsp_rdata", 32'(rsp_rdata), 32'(rv));
      ready = 1'b1;
      @(negedge clk);                      // idle
      expect_pins(0);
   endtask

   initial begin
      #(200000 * 20);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired at %0t", $time);
      report();
      $finish;
   end

   initial begin
      e_addr = '0; e_mio = 0; e_wr = 0; e_wdata = '0; e_bhe = 0;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      expect_pins(0);                      // R1 reset state
      rst = 1'b0;
      @(negedge clk);
      expect_pins(0);

      for (int wr = 0; wr < 2; wr++)
         for (int m = 0; m < 2; m++)
            for (int b = 0; b < 2; b++)
               for (int nw = 0; nw < 5; nw++)
                  for (int ai = 0; ai < 2; ai++) begin
                     logic [AW-1:0] a;
                     logic [DW-1:0] wd;
                     logic [DW-1:0] rv;
                     a  = AW'(32'h2A5C3 * (ai + 1) + nw * 32'h1357 + b * 32'h8000);
                     wd = DW'(16'hC3A5 ^ (nw * 16'h0101) ^ (m << 7) ^ ai);
                     rv = DW'(16'h6E2B + nw * 16'h0203 + ai * 16'h4000 + m);
                     run_cycle(a, m[0], wr[0], wd, b[0], nw, rv, (nw % 2) == 1);
                  end

      // R1: reset inside a wait state
      @(negedge clk);
      req_addr = 20'hF1234; req_mio = 1'b1; req_wr = 1'b0; req_bhe = 1'b1;
      req_valid = 1'b1;
      @(negedge clk);                      // T1
      req_valid = 1'b0; ready = 1'b0;
      @(negedge clk);                      // T2
      @(negedge clk);                      // T3
      @(negedge clk);                      // Tw
      chk("R6 wait held", 32'(rd_n), 32'd0);
      rst = 1'b1;
      @(negedge clk);
      e_wr = 0; e_mio = 0; e_bhe = 0;
      expect_pins(0);                      // R1 mid-cycle reset
      rst = 1'b0; ready = 1'b1;
      @(negedge clk);
      expect_pins(0);
      run_cycle(20'h0ABCD, 1'b0, 1'b1, 16'h9E37, 1'b0, 2, 16'h0, 1'b0);
      run_cycle(20'hFFFF0, 1'b1, 1'b0, 16'h0, 1'b1, 0, 16'hFFFF, 1'b0);

      report();
      $finish;
   end

endmodule